// File: doc/BRIEF.md
# Receive-Ready Flag and Interrupt Register Block

This block sits beside the message storage of a message-based communication controller that has 16 receive objects. When the buffer logic finishes storing a newly arrived message into object n, it pulses a store event carrying n. The block then latches a ready flag for that object. Software sees the flags through a byte-wide register port. It acknowledges an object by writing a 0 into that object's bit. A 1 written into a bit leaves that flag as it is.

Each object also has an interrupt-enable bit in a second pair of registers. The block drives one receive-interrupt level. That level is high when the global receive gate input is high and at least one object has both its flag and its enable bit set. The output is registered, so it follows the flag and mask state with one cycle of delay. Register offsets are fixed. Flags for objects 0..7 are at 04h and flags for objects 8..15 are at 05h. The enables for the same two groups are at 06h and 07h. Within each register, the bit position is the object index modulo 8.

Top module: `rx_ready_block`

## Requirements
- R1: After reset, registers 04h, 05h, 06h and 07h all read 00h and rxIrq is 0.
- R2: A cycle with storeValid=1 and storeIdx=n sets flag n. Flag n appears at bit n%8 of offset 04h for n<8, and of offset 05h for n>=8. No other flag changes.
- R3: A write to 04h or 05h clears every flag whose data bit is 0. A data bit of 1 leaves its flag unchanged, so a write can never set a flag.
- R4: A flag stays set through any number of reads and idle cycles. Only a write of 0 to its bit clears it.
- R5: If a store event and a clearing write hit the same flag in one cycle, the flag ends up set.
- R6: Offsets 06h and 07h are plain read/write enable registers for objects 0..7 and 8..15, with the bit position equal to the object index modulo 8.
- R7: On each clock edge, rxIrq takes the value rxGate AND the OR over all objects of (flag AND enable), evaluated on the state before that edge.
- R8: While rxGate is 0, rxIrq is 0 on the following cycle, whatever the flags and enables hold.
- R9: Reads of any offset other than 04h..07h return 00h. Writes to those offsets change no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register offset for reads and writes |
| regWrEn | input | 1 | Write strobe for regWrData at regAddr |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Contents of the register at regAddr (combinational) |
| storeValid | input | 1 | Single-cycle pulse: a message has been stored |
| storeIdx | input | 4 | Index of the object that was written |
| rxGate | input | 1 | Global receive-interrupt enable |
| rxIrq | output | 1 | Registered receive-interrupt level |

## Verification
A flag bit stuck high, or one lost on a store or on a set/clear collision, shows up at regRdData on the very next read of its register. If such a bit is enabled, it also shows up at rxIrq one edge later. A wrong enable bit or a leaky gate never corrupts the readable flags, so it is seen only at rxIrq, one cycle after the state that should have produced the level. The bench therefore compares both outputs against a reference model every cycle. Its long random phase keeps flags and enables mixed so that single-bit faults reach the interrupt quickly.

// File: rtl/rx_ready_pkg.sv
package rx_ready_pkg;
  localparam int OBJ_CNT = 16;
  localparam int REG_W   = 8;
  localparam int BANKS   = OBJ_CNT / REG_W;
  localparam int IDX_W   = $clog2(OBJ_CNT);

  // Strobes from the decode control to the register datapath
  typedef struct packed {
    logic [BANKS-1:0]   flagWr;
    logic [BANKS-1:0]   maskWr;
    logic [BANKS-1:0]   flagRd;
    logic [BANKS-1:0]   maskRd;
    logic [OBJ_CNT-1:0] setHit;
  } strobe_t;
endpackage

// File: rtl/rx_ready_ctrl.sv
module rx_ready_ctrl
  import rx_ready_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int FLAG_BASE = 4,
  parameter int MASK_BASE = 6
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              storeValid,
  input  logic [IDX_W-1:0]  storeIdx,
  output strobe_t           strobes
);
  always_comb begin
    strobes = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (regAddr == ADDR_W'(FLAG_BASE + b)) begin
        strobes.flagRd[b] = 1'b1;
        strobes.flagWr[b] = regWrEn;
      end
      if (regAddr == ADDR_W'(MASK_BASE + b)) begin
        strobes.maskRd[b] = 1'b1;
        strobes.maskWr[b] = regWrEn;
      end
    end
    if (storeValid) strobes.setHit[storeIdx] = 1'b1;
  end
endmodule

// File: rtl/rx_ready_dp.sv
module rx_ready_dp
  import rx_ready_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic             rxGate,
  output logic [REG_W-1:0] rdData,
  output logic             rxIrq
);
  logic [OBJ_CNT-1:0] flagQ;
  logic [OBJ_CNT-1:0] maskQ;
  logic               irqQ;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [REG_W-1:0] flagCur;
    logic [REG_W-1:0] flagNext;
    assign flagCur  = flagQ[b*REG_W +: REG_W];
    // Hardware set is OR-ed last so it wins over a clearing write (R5)
    assign flagNext = (strobes.flagWr[b] ? (flagCur & wrData) : flagCur)
                    | strobes.setHit[b*REG_W +: REG_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[b*REG_W +: REG_W] <= '0;
        maskQ[b*REG_W +: REG_W] <= '0;
      end else begin
        flagQ[b*REG_W +: REG_W] <= flagNext;
        if (strobes.maskWr[b]) maskQ[b*REG_W +: REG_W] <= wrData;
      end
    end

    for (genvar j = 0; j < REG_W; j++) begin : g_bit
      localparam int N = b*REG_W + j;
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
        strobes.setHit[N] |=> flagQ[N]);
      a_r4_no_self_clear: assert property (@(posedge clk) disable iff (!rstN)
        flagQ[N] && !strobes.flagWr[b] |=> flagQ[N]);
      a_r2_only_store_sets: assert property (@(posedge clk) disable iff (!rstN)
        !flagQ[N] && !strobes.setHit[N] |=> !flagQ[N]);
      a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
        strobes.flagWr[b] && !wrData[j] && !strobes.setHit[N] |=> !flagQ[N]);
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (strobes.flagRd[b]) rdData = rdData | flagQ[b*REG_W +: REG_W];
      if (strobes.maskRd[b]) rdData = rdData | maskQ[b*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= rxGate & (|(flagQ & maskQ));
  end
  assign rxIrq = irqQ;

  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !rxGate |=> !rxIrq);
  a_r7_irq_needs_pair: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ & maskQ) == '0 |=> !rxIrq);
  a_r2_single_store: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.setHit));
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.flagRd, strobes.maskRd}));
endmodule

// File: rtl/rx_ready_block.sv
module rx_ready_block
  import rx_ready_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int FLAG_BASE = 4,
  parameter int MASK_BASE = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              storeValid,
  input  logic [IDX_W-1:0]  storeIdx,
  input  logic              rxGate,
  output logic              rxIrq
);
  strobe_t strobes;

  rx_ready_ctrl #(
    .ADDR_W(ADDR_W), .FLAG_BASE(FLAG_BASE), .MASK_BASE(MASK_BASE)
  ) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn),
    .storeValid(storeValid), .storeIdx(storeIdx),
    .strobes(strobes)
  );

  rx_ready_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .rxGate(rxGate), .rdData(regRdData), .rxIrq(rxIrq)
  );
endmodule

// File: tb/rx_ready_block_tb.sv
module rx_ready_block_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       storeValid = 1'b0;
  logic [3:0] storeIdx = '0;
  logic       rxGate = 1'b0;
  logic       rxIrq;

  int total = 0;
  int bad = 0;
  bit [15:0] mFlag = '0;
  bit [15:0] mMask = '0;

  always #4 clk = ~clk;

  rx_ready_block u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .storeValid(storeValid),
    .storeIdx(storeIdx), .rxGate(rxGate), .rxIrq(rxIrq)
  );

  function automatic bit [7:0] modelRead(input bit [7:0] a);
    case (a)
      8'h04: return mFlag[7:0];
      8'h05: return mFlag[15:8];
      8'h06: return mMask[7:0];
      8'h07: return mMask[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, check read data, clock, check interrupt, update model
  task automatic step(input string tag, input bit we, input bit [7:0] a, input bit [7:0] d,
                      input bit sv, input bit [3:0] idx, input bit gate);
    bit [15:0] nFlag;
    bit [15:0] nMask;
    bit        expIrq;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d;
    storeValid = sv; storeIdx = idx; rxGate = gate;
    #1;
    check(tag, "read", regRdData, modelRead(a));
    nFlag = mFlag; nMask = mMask;
    expIrq = gate && ((mFlag & mMask) != 0);
    if (we && a == 8'h04) nFlag[7:0]  = mFlag[7:0]  & d;
    if (we && a == 8'h05) nFlag[15:8] = mFlag[15:8] & d;
    if (we && a == 8'h06) nMask[7:0]  = d;
    if (we && a == 8'h07) nMask[15:8] = d;
    if (sv) nFlag[idx] = 1'b1;
    @(posedge clk);
    #1;
    check(gate ? "R7" : "R8", "irq", rxIrq, expIrq);
    mFlag = nFlag; mMask = nMask;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    check("R1", "irq", rxIrq, 0);
    for (int a = 4; a < 8; a++) step("R1", 0, 8'(a), 0, 0, 0, 1);
    // R2: hardware set, positions in both flag registers
    step("R2", 0, 8'h04, 0, 1, 4'd3, 0);
    step("R2", 0, 8'h05, 0, 1, 4'd12, 0);
    step("R2", 0, 8'h04, 0, 0, 0, 0);
    step("R2", 0, 8'h05, 0, 0, 0, 0);
    check("R2", "flag byte hi", regRdData, 8'h10);
    // R3: writing ones keeps, zeros clear
    step("R3", 1, 8'h04, 8'hFF, 0, 0, 0);
    step("R3", 0, 8'h04, 0, 0, 0, 0);
    check("R3", "flag byte lo", regRdData, 8'h08);
    step("R3", 1, 8'h04, 8'hF7, 0, 0, 0);
    step("R3", 0, 8'h04, 0, 0, 0, 0);
    // R4: persistence over reads and idle cycles
    for (int k = 0; k < 5; k++) step("R4", 0, 8'h05, 0, 0, 0, 0);
    check("R4", "flag byte hi held", regRdData, 8'h10);
    // R6: mask registers
    step("R6", 1, 8'h06, 8'h5A, 0, 0, 0);
    step("R6", 1, 8'h07, 8'hA5, 0, 0, 0);
    step("R6", 0, 8'h06, 0, 0, 0, 0);
    step("R6", 0, 8'h07, 0, 0, 0, 0);
    // R7: flag 12 with mask bit 4 of 07h (0xA5 -> bit4 = 0) stays quiet, then object 1
    step("R7", 0, 8'h04, 0, 0, 0, 1);
    step("R7", 0, 8'h04, 0, 1, 4'd1, 1);
    step("R7", 0, 8'h04, 0, 0, 0, 1);
    check("R7", "irq high", rxIrq, 1);
    // R8: gate low blocks
    step("R8", 0, 8'h04, 0, 0, 0, 0);
    step("R8", 0, 8'h04, 0, 0, 0, 0);
    check("R8", "irq blocked", rxIrq, 0);
    // R5: set and clear on the same flag in one cycle
    step("R5", 1, 8'h05, 8'h00, 1, 4'd9, 0);
    step("R5", 0, 8'h05, 0, 0, 0, 0);
    check("R5", "flag 9 kept", regRdData, 8'h02);
    // R9: unmapped offsets
    step("R9", 1, 8'h03, 8'h00, 0, 0, 1);
    step("R9", 1, 8'h14, 8'h00, 0, 0, 1);
    step("R9", 0, 8'h08, 0, 0, 0, 1);
    step("R9", 0, 8'hFF, 0, 0, 0, 1);
    step("R9", 0, 8'h04, 0, 0, 0, 1);
    step("R9", 0, 8'h06, 0, 0, 0, 1);
    // Mixed random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      bit [7:0] a;
      a = (($urandom % 8) == 0) ? 8'($urandom) : 8'(4 + ($urandom % 4));
      step("R7", ($urandom % 3) == 0, a, 8'($urandom | $urandom),
           ($urandom % 4) == 0, 4'($urandom), ($urandom % 5) != 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule